// File: doc/BRIEF.md
# Key-Value Query Dispatcher

This block sits in a switch pipeline after the header parser. It takes one parsed key-value request at a time. Each request carries an operation code, a sequence number, a 128-bit key, a value, the source and destination addresses, and a flag that marks traffic on the reserved key-value transport port. The block keeps a small table of cached keys, and each key has a live bit. The values for those keys sit in an external store. The block reaches that store through a request port, and read data comes back later on a response port.

For a read whose key is live in the table, the block fetches the value and sends a reply straight back to the client. Reads that miss go on to the storage server. Writes and deletes clear the live bit before they are forwarded, so the switch never answers with stale data. Cache-update requests come from the management side. They load a value into the store and make the key live, and they are consumed by the block. Every read produces a statistics strobe that says whether it hit. All other traffic passes through untouched.

Top module: `kv_query_dispatch`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `stat_valid` and `val_req_valid` are 0. The table holds no live key, so the first read misses.
- R2: An accepted packet with `in_kv` = 0 appears on the output the next cycle with every field unchanged and `out_reply` = 0. It raises no statistics strobe and leaves the table unchanged.
- R3: A read (op 0) whose key is live issues a store read for that key's slot in the cycle it is accepted. The cycle after the store responds, the block emits a reply: `out_reply` = 1, the value returned by the store, source and destination swapped, and the sequence number, key and op kept. This cycle also carries a statistics strobe with `stat_hit` = 1.
- R4: From the cycle after a read hit is accepted until the reply is emitted, `in_ready` stays 0.
- R5: A read that misses is forwarded unchanged the next cycle with `out_reply` = 0. It raises a statistics strobe with `stat_hit` = 0 and `stat_key` equal to the key.
- R6: A write (op 1) or delete (op 2) clears the live bit of a matching entry at the acceptance edge. It is forwarded unchanged the next cycle and raises no statistics strobe. Reads of that key then miss.
- R7: A cache-update (op 3) writes its value to the store at the key's slot and makes the key live. If the key already owns a slot, live or not, that slot is reused. The request is consumed and produces no output.
- R8: A cache-update for a key that owns no slot takes the slot under a round-robin pointer, which starts at slot 0 after reset and advances by one per new key. It evicts whatever key held that slot.
- R9: Any other op code on the key-value port is forwarded unchanged, with no statistics strobe and no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_kv | input | 1 | Packet is on the reserved key-value port |
| in_op | input | OP_W | Operation code |
| in_seq | input | SEQ_W | Sequence number |
| in_key | input | KEY_W | Key |
| in_value | input | VAL_W | Value field |
| in_src | input | ADDR_W | Source address |
| in_dst | input | ADDR_W | Destination address |
| out_valid | output | 1 | Output packet present |
| out_reply | output | 1 | 1: reply to client, 0: forwarded |
| out_kv | output | 1 | Key-value port flag of output |
| out_op | output | OP_W | Operation code |
| out_seq | output | SEQ_W | Sequence number |
| out_key | output | KEY_W | Key |
| out_value | output | VAL_W | Value field |
| out_src | output | ADDR_W | Source address |
| out_dst | output | ADDR_W | Destination address |
| stat_valid | output | 1 | Statistics strobe for a read |
| stat_hit | output | 1 | The read hit the cache |
| stat_key | output | KEY_W | Key of the counted read |
| val_req_valid | output | 1 | Store request |
| val_req_write | output | 1 | 1: write, 0: read |
| val_req_idx | output | IDX_W | Store slot |
| val_req_data | output | VAL_W | Write data |
| val_rsp_valid | input | 1 | Store read data present |
| val_rsp_data | input | VAL_W | Store read data |

## Verification
The bench reads a key right after a write or delete of that key. A design that kept the live bit set would answer with the old value instead of forwarding the request. A cache-update to a key that was invalidated must reuse its slot. If it does not, later round-robin eviction lands on the wrong keys and the eviction reads return wrong hits or misses. A bypass packet whose op is read checks that traffic off the key-value port is neither answered nor counted. A design that ignored the port flag would emit a reply or a strobe. The bench watches `in_ready` while a hit is waiting on the slow store, so a block that took new work during that time would lose or reorder the reply.

// File: rtl/kv_query_dispatch.sv
module kv_query_dispatch #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 128,
  parameter int VAL_W   = 64,
  parameter int OP_W    = 8,
  parameter int SEQ_W   = 32,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_kv,
  input  logic [OP_W-1:0]   in_op,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [VAL_W-1:0]  in_value,
  input  logic [ADDR_W-1:0] in_src,
  input  logic [ADDR_W-1:0] in_dst,
  output logic              out_valid,
  output logic              out_reply,
  output logic              out_kv,
  output logic [OP_W-1:0]   out_op,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [KEY_W-1:0]  out_key,
  output logic [VAL_W-1:0]  out_value,
  output logic [ADDR_W-1:0] out_src,
  output logic [ADDR_W-1:0] out_dst,
  output logic              stat_valid,
  output logic              stat_hit,
  output logic [KEY_W-1:0]  stat_key,
  output logic              val_req_valid,
  output logic              val_req_write,
  output logic [IDX_W-1:0]  val_req_idx,
  output logic [VAL_W-1:0]  val_req_data,
  input  logic              val_rsp_valid,
  input  logic [VAL_W-1:0]  val_rsp_data
);

  localparam logic [OP_W-1:0] OP_RD  = OP_W'(0);
  localparam logic [OP_W-1:0] OP_WR  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_DEL = OP_W'(2);
  localparam logic [OP_W-1:0] OP_UPD = OP_W'(3);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(ENTRIES - 1);

  logic [KEY_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] alloc_q, live_q, match;
  logic [IDX_W-1:0]   rr_q, match_idx, upd_idx;
  logic               wait_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = alloc_q[i] && (tag_q[i] == in_key);
  end

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) match_idx = IDX_W'(i);
  end

  wire any_match = |match;
  wire hit       = |(match & live_q);
  wire acc       = in_valid && in_ready;
  wire kv_acc    = acc && in_kv;
  wire is_rd     = in_op == OP_RD;
  wire is_inv    = (in_op == OP_WR) || (in_op == OP_DEL);
  wire is_upd    = in_op == OP_UPD;
  wire rd_hit    = kv_acc && is_rd && hit;
  wire upd       = kv_acc && is_upd;

  assign upd_idx       = any_match ? match_idx : rr_q;
  assign in_ready      = !wait_q;
  assign val_req_valid = rd_hit || upd;
  assign val_req_write = upd;
  assign val_req_idx   = upd ? upd_idx : match_idx;
  assign val_req_data  = in_value;

  always_ff @(posedge clk)
    if (upd) tag_q[upd_idx] <= in_key;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q     <= 1'b0;
      alloc_q    <= '0;
      live_q     <= '0;
      rr_q       <= '0;
      out_valid  <= 1'b0;
      out_reply  <= 1'b0;
      out_kv     <= 1'b0;
      out_op     <= '0;
      out_seq    <= '0;
      out_key    <= '0;
      out_value  <= '0;
      out_src    <= '0;
      out_dst    <= '0;
      stat_valid <= 1'b0;
      stat_hit   <= 1'b0;
      stat_key   <= '0;
    end else begin
      out_valid  <= 1'b0;
      stat_valid <= 1'b0;
      if (wait_q) begin
        if (val_rsp_valid) begin
          wait_q     <= 1'b0;
          out_valid  <= 1'b1;
          out_value  <= val_rsp_data;
          stat_valid <= 1'b1;
          stat_hit   <= 1'b1;
          stat_key   <= out_key;
        end
      end else if (acc) begin
        if (rd_hit) begin
          wait_q    <= 1'b1;
          out_reply <= 1'b1;
          out_kv    <= 1'b1;
          out_op    <= in_op;
          out_seq   <= in_seq;
          out_key   <= in_key;
          out_src   <= in_dst;
          out_dst   <= in_src;
        end else if (!upd) begin
          out_valid  <= 1'b1;
          out_reply  <= 1'b0;
          out_kv     <= in_kv;
          out_op     <= in_op;
          out_seq    <= in_seq;
          out_key    <= in_key;
          out_value  <= in_value;
          out_src    <= in_src;
          out_dst    <= in_dst;
          stat_valid <= in_kv && is_rd;
          stat_hit   <= 1'b0;
          stat_key   <= in_key;
        end
        if (in_kv && is_inv) live_q <= live_q & ~match;
        if (upd) begin
          live_q[upd_idx]  <= 1'b1;
          alloc_q[upd_idx] <= 1'b1;
          if (!any_match) rr_q <= (rr_q == LAST) ? '0 : rr_q + IDX_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/kv_query_dispatch_chk.sv
module kv_query_dispatch_chk #(
  parameter int KEY_W = 128,
  parameter int OP_W  = 8,
  parameter int SEQ_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_kv,
  input logic [OP_W-1:0]  in_op,
  input logic [SEQ_W-1:0] in_seq,
  input logic [KEY_W-1:0] in_key,
  input logic             out_valid,
  input logic             out_reply,
  input logic [SEQ_W-1:0] out_seq,
  input logic [KEY_W-1:0] out_key,
  input logic             stat_valid,
  input logic             stat_hit,
  input logic             val_req_valid,
  input logic             val_req_write
);

  wire acc = in_valid && in_ready;

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_kv |=> out_valid && !out_reply && !stat_valid
                      && out_key == $past(in_key) && out_seq == $past(in_seq));

  // R3
  reply_counts_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_reply |-> stat_valid && stat_hit);

  // R4
  hit_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    val_req_valid && !val_req_write |=> !in_ready);

  // R5
  miss_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !stat_hit |-> out_valid && !out_reply);

  // R6
  inval_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_kv && (in_op == OP_W'(1) || in_op == OP_W'(2))
      |=> out_valid && !out_reply && !stat_valid);

  // R7
  update_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    val_req_valid && val_req_write |=> !out_valid);

endmodule

bind kv_query_dispatch kv_query_dispatch_chk #(.KEY_W(KEY_W), .OP_W(OP_W), .SEQ_W(SEQ_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_kv(in_kv),
  .in_op(in_op), .in_seq(in_seq), .in_key(in_key), .out_valid(out_valid),
  .out_reply(out_reply), .out_seq(out_seq), .out_key(out_key), .stat_valid(stat_valid),
  .stat_hit(stat_hit), .val_req_valid(val_req_valid), .val_req_write(val_req_write)
);

// File: tb/test_kv_query_dispatch.sv
`timescale 1ns/1ps
module test_kv_query_dispatch;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         in_valid = 1'b0, in_kv = 1'b0;
  logic [7:0]   in_op = '0;
  logic [31:0]  in_seq = '0, in_src = '0, in_dst = '0;
  logic [127:0] in_key = '0;
  logic [63:0]  in_value = '0;
  logic         in_ready, out_valid, out_reply, out_kv, stat_valid, stat_hit;
  logic [7:0]   out_op;
  logic [31:0]  out_seq, out_src, out_dst;
  logic [127:0] out_key, stat_key;
  logic [63:0]  out_value, val_req_data;
  logic         val_req_valid, val_req_write;
  logic [2:0]   val_req_idx;
  logic         val_rsp_valid;
  logic [63:0]  val_rsp_data;

  kv_query_dispatch i_kv_query_dispatch (.*);

  logic [63:0] mem [8];
  logic        p1;
  logic [2:0]  p1_idx;
  always @(posedge clk) begin
    if (!rst_n) begin
      p1 <= 1'b0; val_rsp_valid <= 1'b0; val_rsp_data <= '0;
    end else begin
      p1 <= val_req_valid && !val_req_write;
      p1_idx <= val_req_idx;
      if (val_req_valid && val_req_write) mem[val_req_idx] <= val_req_data;
      val_rsp_valid <= p1;
      val_rsp_data  <= mem[p1_idx];
    end
  end

  int n_checks = 0, n_err = 0, n_out = 0, n_stat = 0;
  logic cap_reply, cap_hit;
  logic [7:0]   cap_op;
  logic [31:0]  cap_seq, cap_src, cap_dst;
  logic [127:0] cap_key, cap_skey;
  logic [63:0]  cap_val;
  always @(negedge clk) begin
    if (out_valid) begin
      n_out++; cap_reply = out_reply; cap_op = out_op; cap_seq = out_seq;
      cap_key = out_key; cap_val = out_value; cap_src = out_src; cap_dst = out_dst;
    end
    if (stat_valid) begin n_stat++; cap_hit = stat_hit; cap_skey = stat_key; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic kv; logic [7:0] op; logic [15:0] key; logic [15:0] val;
    logic eo; logic er; logic es; logic eh; logic [15:0] ev;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{1'b1, 8'd0, 16'd5, 16'h0,  1'b1, 1'b0, 1'b1, 1'b0, 16'h0 },  // R5 R1 miss after reset
    '{1'b1, 8'd3, 16'd5, 16'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0 },  // R7 install
    '{1'b1, 8'd0, 16'd5, 16'h0,  1'b1, 1'b1, 1'b1, 1'b1, 16'hAA},  // R3 hit
    '{1'b1, 8'd3, 16'd9, 16'hBB, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0 },  // R7
    '{1'b1, 8'd0, 16'd9, 16'h0,  1'b1, 1'b1, 1'b1, 1'b1, 16'hBB},  // R3
    '{1'b1, 8'd1, 16'd5, 16'h77, 1'b1, 1'b0, 1'b0, 1'b0, 16'h77},  // R6 write
    '{1'b1, 8'd0, 16'd5, 16'h0,  1'b1, 1'b0, 1'b1, 1'b0, 16'h0 },  // R6 now miss
    '{1'b1, 8'd3, 16'd5, 16'hCC, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0 },  // R7 revalidate
    '{1'b1, 8'd0, 16'd5, 16'h0,  1'b1, 1'b1, 1'b1, 1'b1, 16'hCC},  // R7 R3
    '{1'b1, 8'd2, 16'd9, 16'h0,  1'b1, 1'b0, 1'b0, 1'b0, 16'h0 },  // R6 delete
    '{1'b1, 8'd0, 16'd9, 16'h0,  1'b1, 1'b0, 1'b1, 1'b0, 16'h0 },  // R6 miss
    '{1'b1, 8'd7, 16'd5, 16'h12, 1'b1, 1'b0, 1'b0, 1'b0, 16'h12},  // R9 other op
    '{1'b0, 8'd0, 16'd5, 16'h34, 1'b1, 1'b0, 1'b0, 1'b0, 16'h34},  // R2 bypass
    '{1'b1, 8'd0, 16'd5, 16'h0,  1'b1, 1'b1, 1'b1, 1'b1, 16'hCC}   // R2 R9 still hit
  };

  function automatic string req_of(input int i);
    case (i)
      0, 6: return "R5";
      1, 3, 7, 8: return "R7";
      2, 4: return "R3";
      5, 9, 10: return "R6";
      11: return "R9";
      12, 13: return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic run(input int i, input vec_t v, input bit chk_stall);
    logic [31:0] src = 32'hA000_0000 + i, dst = 32'hB000_0000 + i, seq = 1000 + i;
    string r = req_of(i);
    n_out = 0; n_stat = 0;
    @(negedge clk);
    in_valid = 1'b1; in_kv = v.kv; in_op = v.op; in_key = {112'h0, v.key};
    in_value = {48'h0, v.val}; in_src = src; in_dst = dst; in_seq = seq;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (chk_stall) chk(in_ready == 1'b0, "R4", "in_ready while hit pending", in_ready, 0);
    repeat (6) @(negedge clk);
    chk(n_out == int'(v.eo), r, "output count", n_out, v.eo);
    chk(n_stat == int'(v.es), r, "stat count", n_stat, v.es);
    if (v.es && n_stat == 1) chk(cap_hit == v.eh, r, "stat_hit", cap_hit, v.eh);
    if (v.es && n_stat == 1) chk(cap_skey == {112'h0, v.key}, r, "stat_key", cap_skey, v.key);
    if (v.eo && n_out == 1) begin
      chk(cap_reply == v.er, r, "out_reply", cap_reply, v.er);
      chk(cap_val == {48'h0, v.ev}, r, "out_value", cap_val, v.ev);
      chk(cap_key == {112'h0, v.key} && cap_seq == seq && cap_op == v.op, r, "key/seq/op",
          cap_seq, seq);
      chk(cap_src == (v.er ? dst : src) && cap_dst == (v.er ? src : dst), r, "addresses",
          {cap_src, cap_dst}, v.er ? {dst, src} : {src, dst});
    end
  endtask

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready && !out_valid && !stat_valid && !val_req_valid, "R1", "reset outputs",
        {in_ready, out_valid, stat_valid, val_req_valid}, 4'b1000);
    rst_n = 1'b1;
    for (int i = 0; i < 14; i++) run(i, VEC[i], VEC[i].eh);
    // R8: eight new keys fill slots 2..7 then 0 and 1, evicting keys 5 and 9
    for (int k = 0; k < 8; k++)
      run(100 + k, '{1'b1, 8'd3, 16'(100 + k), 16'(16'h200 + k), 1'b0, 1'b0, 1'b0, 1'b0, 16'h0}, 1'b0);
    run(120, '{1'b1, 8'd0, 16'd5,   16'h0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0},   1'b0);
    run(121, '{1'b1, 8'd0, 16'd100, 16'h0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h200}, 1'b0);
    run(122, '{1'b1, 8'd0, 16'd107, 16'h0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h207}, 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule